// File: doc/BRIEF.md
# Multicycle Shared-Unit Processor Core

This block executes a small 32-bit load/store instruction subset (register-register arithmetic and logic, word load, word store, branch on equal, and unconditional jump) by splitting every instruction into one-cycle steps. Only one memory and one ALU exist. The memory holds both program and data. The ALU computes the program-counter increment, the branch target, the load/store address and the arithmetic result, each in a different cycle.

Operand multiplexers steer the shared units, and a set of holding registers carries values from one step to the next. These are the instruction register, the memory data register, the two register-file operand latches and the ALU result latch. A finite-state sequencer drives every select and write enable. The program memory is an internal array; the environment fills it before releasing reset.

The core exposes its program counter, a fetch-step marker, and the write traffic going to memory and to the register file. Execution is observed through these ports.

Top module: `mc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the PC reads 0, the fetch marker is high, and neither write enable is active.
- R2: The PC stays word aligned. At the end of every fetch step it becomes the fetched address plus 4.
- R3: Instructions take a fixed number of cycles, counted from one fetch step to the next: a jump or branch-on-equal takes 3, a register-register operation or store takes 4, and a load takes 5.
- R4: For a register-register instruction (opcode 0x00), the function field in bits [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. The result is written to the register named in bits [15:11], in the instruction's last cycle.
- R5: A load (opcode 0x23) reads the word at rs + sign-extended bits [15:0] and writes it to the register named in bits [20:16]. The source register rs is taken from bits [25:21].
- R6: A store (opcode 0x2B) writes the rt register to rs + sign-extended bits [15:0], with exactly one memory write cycle and no register write. A later load from that address returns the stored word.
- R7: Branch-on-equal (opcode 0x04) sets the PC to PC+4 + (sign-extended bits [15:0] shifted left by 2) when rs equals rt, and to PC+4 otherwise. A negative offset branches backwards.
- R8: A jump (opcode 0x02) sets the PC to the upper 4 bits of PC+4 joined with bits [25:0] shifted left by 2.
- R9: Register 0 reads as zero even after an instruction names it as a destination.
- R10: In no cycle are the memory write and the register-file write both active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Current program counter (byte address) |
| fetch_o | output | 1 | High during the fetch step of each instruction |
| mem_we_o | output | 1 | Memory write enable in this cycle |
| mem_addr_o | output | 32 | Byte address presented to the memory |
| mem_wdata_o | output | 32 | Data presented for a memory write |
| rf_we_o | output | 1 | Register-file write enable in this cycle |
| rf_waddr_o | output | 5 | Register-file destination number |
| rf_wdata_o | output | 32 | Register-file write data |

## Verification
The bench goes after four kinds of mistake.

- Operand sign and ordering. A negative loaded value feeds every ALU function, and set-less-than runs in both operand orders, so a core that compares unsigned or swaps its operands writes a wrong result.
- Branch targets. A branch that falls through, a taken branch that must skip filler stores, and a branch with offset -1 that must spin on itself together expose a core that tests the zero flag wrongly, drops the sign extension, or takes the target from the live ALU output instead of the latched one.
- Register 0 and the store path. A write aimed at register 0 is followed by a read of it, which catches a core that lets the write land. Reloading the address just stored to catches a store with a wrong address or wrong data.
- Cycle counts. Every instruction's length is measured, so an extra or missing step in the sequencer shows up as a count error.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [3:0] {
      S_FETCH, S_DECODE, S_MEMADR, S_MEMRD, S_MEMWB,
      S_MEMWR, S_EXEC, S_RWB, S_BRANCH, S_JUMP
   } state_t;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
   } alufn_t;

   typedef enum logic [1:0] {
      AOP_ADD, AOP_SUB, AOP_FUNCT
   } aluop_t;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_JUMP  = 6'h02;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   // step controls: selects and enables for one cycle
   typedef struct packed {
      logic       addr_alu;   // memory address from ALU latch instead of PC
      logic       ir_load;
      logic       mem_wr;
      logic       rf_wr;
      logic       pc_ld;
      logic       pc_ld_eq;   // load PC only when ALU result is zero
      logic       opa_reg;    // ALU operand A from A latch instead of PC
      logic [1:0] opb_sel;    // 0 B latch, 1 const 4, 2 imm, 3 imm<<2
      aluop_t     aluop;
      logic [1:0] pc_sel;     // 0 ALU result, 1 ALU latch, 2 jump target
      logic       dst_rd;     // destination from bits [15:11]
      logic       wb_mem;     // write-back data from memory data latch
   } ctl_t;

endpackage

// File: rtl/mc_mem.sv
module mc_mem #(
   parameter int DW    = 32,
   parameter int WORDS = 256,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   generate
      if (WORDS < 4 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("mc_mem: WORDS must be a power of two of at least 4");
      end
   endgenerate

   logic [DW-1:0] mem_q [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem_q[addr] <= wdata;
   end

   assign rdata = mem_q[addr];

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int DW   = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [DW-1:0] rd1,
   output logic [DW-1:0] rd2
);

   generate
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("mc_regfile: NREG must be a power of two of at least 2");
      end
   endgenerate

   logic [NREG*DW-1:0] flat;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign flat[DW-1:0] = '0;
      end else begin : g_store
         logic [DW-1:0] q;
         always_ff @(posedge clk) begin
            if (we && waddr == AW'(g)) q <= wdata;
         end
         assign flat[g*DW +: DW] = q;
      end
   end

   assign rd1 = flat[ra1*DW +: DW];
   assign rd2 = flat[ra2*DW +: DW];

endmodule

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int DW      = 32,
   parameter bit HAS_SLT = 1'b1
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  aluop_t        op,
   input  logic [5:0]    funct,
   output logic [DW-1:0] y,
   output logic          zero
);

   alufn_t        fn;
   logic [DW-1:0] slt_v;

   always_comb begin
      case (op)
         AOP_ADD: fn = ALU_ADD;
         AOP_SUB: fn = ALU_SUB;
         default: begin
            case (funct)
               FN_SUB:  fn = ALU_SUB;
               FN_AND:  fn = ALU_AND;
               FN_OR:   fn = ALU_OR;
               FN_SLT:  fn = ALU_SLT;
               default: fn = ALU_ADD;
            endcase
         end
      endcase
   end

   generate
      if (HAS_SLT) begin : g_slt
         assign slt_v = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      end else begin : g_no_slt
         assign slt_v = '0;
      end
   endgenerate

   always_comb begin
      case (fn)
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = slt_v;
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [5:0] opcode,
   output ctl_t       ctl,
   output state_t     state
);

   state_t state_q, state_d;

   always_ff @(posedge clk) begin
      if (rst) state_q <= S_FETCH;
      else     state_q <= state_d;
   end

   always_comb begin
      case (state_q)
         S_FETCH:  state_d = S_DECODE;
         S_DECODE: begin
            case (opcode)
               OP_LOAD, OP_STORE: state_d = S_MEMADR;
               OP_RTYPE:          state_d = S_EXEC;
               OP_BEQ:            state_d = S_BRANCH;
               OP_JUMP:           state_d = S_JUMP;
               default:           state_d = S_FETCH;
            endcase
         end
         S_MEMADR: state_d = (opcode == OP_LOAD) ? S_MEMRD : S_MEMWR;
         S_MEMRD:  state_d = S_MEMWB;
         S_EXEC:   state_d = S_RWB;
         default:  state_d = S_FETCH;
      endcase
   end

   always_comb begin
      ctl = '0;
      case (state_q)
         S_FETCH: begin
            ctl.ir_load = 1'b1;
            ctl.opb_sel = 2'd1;
            ctl.pc_ld   = 1'b1;
         end
         S_DECODE: ctl.opb_sel = 2'd3;
         S_MEMADR: begin
            ctl.opa_reg = 1'b1;
            ctl.opb_sel = 2'd2;
         end
         S_MEMRD:  ctl.addr_alu = 1'b1;
         S_MEMWB: begin
            ctl.rf_wr  = 1'b1;
            ctl.wb_mem = 1'b1;
         end
         S_MEMWR: begin
            ctl.addr_alu = 1'b1;
            ctl.mem_wr   = 1'b1;
         end
         S_EXEC: begin
            ctl.opa_reg = 1'b1;
            ctl.aluop   = AOP_FUNCT;
         end
         S_RWB: begin
            ctl.rf_wr  = 1'b1;
            ctl.dst_rd = 1'b1;
         end
         S_BRANCH: begin
            ctl.opa_reg  = 1'b1;
            ctl.aluop    = AOP_SUB;
            ctl.pc_ld_eq = 1'b1;
            ctl.pc_sel   = 2'd1;
         end
         S_JUMP: begin
            ctl.pc_sel = 2'd2;
            ctl.pc_ld  = 1'b1;
         end
         default: ;
      endcase
   end

   assign state = state_q;

endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_pkg::*;
#(
   parameter int DW        = 32,
   parameter int MEM_WORDS = 256,
   parameter bit HAS_SLT   = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   output logic [DW-1:0] pc_o,
   output logic          fetch_o,
   output logic          mem_we_o,
   output logic [DW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   output logic          rf_we_o,
   output logic [4:0]    rf_waddr_o,
   output logic [DW-1:0] rf_wdata_o
);

   localparam int MAW  = $clog2(MEM_WORDS);
   localparam int NREG = 32;

   generate
      if (DW != 32) begin : g_bad_dw
         $error("mc_core: the instruction encoding requires DW == 32");
      end
      if (MAW + 2 > DW) begin : g_bad_mem
         $error("mc_core: MEM_WORDS too large for the address width");
      end
   endgenerate

   ctl_t          ctl;
   state_t        state;
   logic [DW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
   logic [DW-1:0] mem_addr, mem_rdata;
   logic [DW-1:0] opa, opb, alu_y, imm_sx, imm_sh, pc_d;
   logic [DW-1:0] rd1, rd2, wb_data;
   logic [4:0]    wb_reg;
   logic          alu_zero, pc_en;

   mc_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .opcode (ir_q[31:26]),
      .ctl    (ctl),
      .state  (state)
   );

   // shared memory: PC for fetch, ALU latch for data
   assign mem_addr = ctl.addr_alu ? aluout_q : pc_q;

   mc_mem #(.DW(DW), .WORDS(MEM_WORDS)) u_mem (
      .clk   (clk),
      .we    (ctl.mem_wr),
      .addr  (mem_addr[MAW+1:2]),
      .wdata (b_q),
      .rdata (mem_rdata)
   );

   assign wb_reg  = ctl.dst_rd ? ir_q[15:11] : ir_q[20:16];
   assign wb_data = ctl.wb_mem ? mdr_q : aluout_q;

   mc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk   (clk),
      .we    (ctl.rf_wr),
      .waddr (wb_reg),
      .wdata (wb_data),
      .ra1   (ir_q[25:21]),
      .ra2   (ir_q[20:16]),
      .rd1   (rd1),
      .rd2   (rd2)
   );

   assign imm_sx = {{(DW-16){ir_q[15]}}, ir_q[15:0]};
   assign imm_sh = {imm_sx[DW-3:0], 2'b00};
   assign opa    = ctl.opa_reg ? a_q : pc_q;

   always_comb begin
      case (ctl.opb_sel)
         2'd0:    opb = b_q;
         2'd1:    opb = DW'(4);
         2'd2:    opb = imm_sx;
         default: opb = imm_sh;
      endcase
   end

   mc_alu #(.DW(DW), .HAS_SLT(HAS_SLT)) u_alu (
      .a     (opa),
      .b     (opb),
      .op    (ctl.aluop),
      .funct (ir_q[5:0]),
      .y     (alu_y),
      .zero  (alu_zero)
   );

   always_comb begin
      case (ctl.pc_sel)
         2'd1:    pc_d = aluout_q;
         2'd2:    pc_d = {pc_q[DW-1:DW-4], ir_q[25:0], 2'b00};
         default: pc_d = alu_y;
      endcase
   end

   assign pc_en = ctl.pc_ld | (ctl.pc_ld_eq & alu_zero);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q     <= '0;
         ir_q     <= '0;
         mdr_q    <= '0;
         a_q      <= '0;
         b_q      <= '0;
         aluout_q <= '0;
      end else begin
         if (pc_en)       pc_q <= pc_d;
         if (ctl.ir_load) ir_q <= mem_rdata;
         mdr_q    <= mem_rdata;
         a_q      <= rd1;
         b_q      <= rd2;
         aluout_q <= alu_y;
      end
   end

   assign pc_o        = pc_q;
   assign fetch_o     = (state == S_FETCH);
   assign mem_we_o    = ctl.mem_wr;
   assign mem_addr_o  = mem_addr;
   assign mem_wdata_o = b_q;
   assign rf_we_o     = ctl.rf_wr;
   assign rf_waddr_o  = wb_reg;
   assign rf_wdata_o  = wb_data;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst,
   input logic [DW-1:0] pc_o,
   input logic          fetch_o,
   input logic          mem_we_o,
   input logic          rf_we_o
);

   AST_RESET_EXIT: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (pc_o == '0 && fetch_o && !mem_we_o && !rf_we_o)); // R1

   AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      pc_o[1:0] == 2'b00); // R2

   AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      fetch_o |=> (pc_o == $past(pc_o) + DW'(4) && !fetch_o)); // R2

   AST_WRITE_ENDS_INSTR: assert property (@(posedge clk) disable iff (rst)
      (rf_we_o || mem_we_o) |=> fetch_o); // R3

   AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
      !(mem_we_o && rf_we_o)); // R10

endmodule

bind mc_core mc_core_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pc_o     (pc_o),
   .fetch_o  (fetch_o),
   .mem_we_o (mem_we_o),
   .rf_we_o  (rf_we_o)
);

// File: tb/sim_mc_core.sv
module sim_mc_core;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pc_o, mem_addr_o, mem_wdata_o, rf_wdata_o;
   logic        fetch_o, mem_we_o, rf_we_o;
   logic [4:0]  rf_waddr_o;

   always #5 clk = ~clk;

   mc_core u0 (
      .clk         (clk),
      .rst         (rst),
      .pc_o        (pc_o),
      .fetch_o     (fetch_o),
      .mem_we_o    (mem_we_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .rf_we_o     (rf_we_o),
      .rf_waddr_o  (rf_waddr_o),
      .rf_wdata_o  (rf_wdata_o)
   );

   int n_chk  = 0;
   int n_fail = 0;

   // per-instruction observations
   int          cyc;
   logic [31:0] pc_start, pc_dec;
   int          n_rfw, n_mw;
   logic [4:0]  wa;
   logic [31:0] wd, ma, md;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [5:0] fn);
      return {6'h00, rs, rt, rd, 5'd0, fn};
   endfunction

   // run one instruction from its fetch step to the next fetch step
   task automatic step();
      bit done = 1'b0;
      cyc = 1; pc_start = pc_o; pc_dec = '0;
      n_rfw = 0; n_mw = 0; wa = '0; wd = '0; ma = '0; md = '0;
      while (!done) begin
         if (rf_we_o)  begin n_rfw++; wa = rf_waddr_o; wd = rf_wdata_o; end
         if (mem_we_o) begin n_mw++;  ma = mem_addr_o; md = mem_wdata_o; end
         @(negedge clk);
         if (cyc == 1) pc_dec = pc_o;
         if (fetch_o || cyc > 12) done = 1'b1;
         else cyc++;
      end
   endtask

   task automatic t_reset();
      chk(pc_o == 32'd0, "R1 reset pc", pc_o, 32'd0);
      chk(fetch_o, "R1 reset fetch marker", 32'(fetch_o), 32'd1);
      chk(!rf_we_o && !mem_we_o, "R1 no writes in reset", {30'd0, rf_we_o, mem_we_o}, 32'd0);
   endtask

   task automatic t_load(input logic [4:0] rt, input logic [31:0] exp);
      step();
      chk(cyc == 5, "R3 load cycles", 32'(cyc), 32'd5);
      chk(pc_dec == pc_start + 32'd4, "R2 pc after fetch", pc_dec, pc_start + 32'd4);
      chk(n_rfw == 1 && wa == rt, "R5 load destination", 32'(wa), 32'(rt));
      chk(wd == exp, "R5 load data", wd, exp);
      chk(n_mw == 0, "R10 load makes no memory write", 32'(n_mw), 32'd0);
   endtask

   task automatic t_rtype(input logic [4:0] rd, input logic [31:0] exp, input string tag);
      step();
      chk(cyc == 4, "R3 register op cycles", 32'(cyc), 32'd4);
      chk(n_rfw == 1 && wa == rd, {"R4 destination ", tag}, 32'(wa), 32'(rd));
      chk(wd == exp, {"R4 result ", tag}, wd, exp);
   endtask

   task automatic t_reg0();
      step();  // add targeting register 0
      chk(n_rfw == 1 && wa == 5'd0, "R9 write aimed at r0", 32'(wa), 32'd0);
      step();  // or r9, r0, r0
      chk(wa == 5'd9 && wd == 32'd0, "R9 r0 reads zero", wd, 32'd0);
   endtask

   task automatic t_store();
      step();
      chk(cyc == 4, "R3 store cycles", 32'(cyc), 32'd4);
      chk(n_mw == 1, "R6 one memory write", 32'(n_mw), 32'd1);
      chk(ma == 32'h108, "R6 store address", ma, 32'h108);
      chk(md == 32'h9B, "R6 store data", md, 32'h9B);
      chk(n_rfw == 0, "R6 store makes no register write", 32'(n_rfw), 32'd0);
   endtask

   task automatic t_branch(input logic [31:0] exp_pc, input string tag);
      step();
      chk(cyc == 3, {"R3 branch cycles ", tag}, 32'(cyc), 32'd3);
      chk(pc_o == exp_pc, {"R7 branch target ", tag}, pc_o, exp_pc);
      chk(n_rfw == 0 && n_mw == 0, {"R7 branch writes nothing ", tag}, 32'(n_rfw + n_mw), 32'd0);
   endtask

   task automatic t_jump();
      step();
      chk(cyc == 3, "R3 jump cycles", 32'(cyc), 32'd3);
      chk(pc_o == 32'h50, "R8 jump target", pc_o, 32'h50);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) u0.u_mem.mem_q[i] = enc_i(6'h2B, 5'd0, 5'd1, 16'h010C);
      u0.u_mem.mem_q[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
      u0.u_mem.mem_q[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h0104);
      u0.u_mem.mem_q[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
      u0.u_mem.mem_q[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'h22);
      u0.u_mem.mem_q[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'h24);
      u0.u_mem.mem_q[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'h25);
      u0.u_mem.mem_q[6]  = enc_r(5'd2, 5'd1, 5'd7, 6'h2A);
      u0.u_mem.mem_q[7]  = enc_r(5'd1, 5'd2, 5'd8, 6'h2A);
      u0.u_mem.mem_q[8]  = enc_r(5'd1, 5'd1, 5'd0, 6'h20);
      u0.u_mem.mem_q[9]  = enc_r(5'd0, 5'd0, 5'd9, 6'h25);
      u0.u_mem.mem_q[10] = enc_i(6'h2B, 5'd0, 5'd3, 16'h0108);
      u0.u_mem.mem_q[11] = enc_i(6'h04, 5'd1, 5'd2, 16'h0005);
      u0.u_mem.mem_q[12] = enc_i(6'h04, 5'd3, 5'd3, 16'h0002);
      u0.u_mem.mem_q[15] = {6'h02, 26'h14};
      u0.u_mem.mem_q[20] = enc_i(6'h23, 5'd0, 5'd12, 16'h0108);
      u0.u_mem.mem_q[21] = enc_i(6'h04, 5'd0, 5'd0, 16'h0001);
      u0.u_mem.mem_q[23] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
      u0.u_mem.mem_q[64] = 32'h0000_00AB;
      u0.u_mem.mem_q[65] = 32'hFFFF_FFF0;

      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_reset();   // first cycle after release, still in fetch at 0

      t_load(5'd1, 32'h0000_00AB);
      t_load(5'd2, 32'hFFFF_FFF0);
      t_rtype(5'd3, 32'h0000_009B, "add");
      t_rtype(5'd4, 32'h0000_00BB, "sub");
      t_rtype(5'd5, 32'h0000_00A0, "and");
      t_rtype(5'd6, 32'hFFFF_FFFB, "or");
      t_rtype(5'd7, 32'h0000_0001, "slt negative<positive");
      t_rtype(5'd8, 32'h0000_0000, "slt positive<negative");
      t_reg0();
      t_store();
      t_branch(32'h30, "not taken");
      t_branch(32'h3C, "taken forward");
      t_jump();
      t_load(5'd12, 32'h0000_009B);   // R6 stored word reads back
      t_branch(32'h5C, "taken over one");
      t_branch(32'h5C, "backward onto itself");
      t_branch(32'h5C, "backward again");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R3 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule